// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block keeps the control/status word of a floating-point unit together with a read-only revision register. Software reaches both through a move-to port and a move-from port, each addressed by a 5-bit control-register index. The arithmetic units report each finished operation on an update port. The port carries five exception indications (inexact, underflow, overflow, divide-by-zero, invalid) and an unimplemented-operation indication. The block keeps the per-operation cause field and the sticky flag field from these reports. It then decides in the same cycle whether the operation traps.

The rounding mode and the flush-to-zero control go straight from the stored word to the arithmetic units. Eight condition-code bits are set or cleared one at a time through a separate port and are also brought out as a vector. When a trap is raised for an operation, that operation's register writeback is held off, but the status word is still updated. A word written through the move-to port is checked for the trap condition in the cycle after the write.

Top module: `fp_ctrl_status`

## Requirements
- R1: After reset the whole word is zero: rounding mode 0 (nearest), flush-to-zero 0, all condition codes 0, no trap request, and a read of index 31 returns 0.
- R2: Only index 31 holds state. A read of any other index (index 0 is the revision register) returns 0, and a move-to on any other index leaves the word unchanged.
- R3: A move-to on index 31 stores the data with bits 22:18 forced to zero. From the next cycle, rnd_mode equals bits 1:0 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf) and flush_zero equals bit 24.
- R4: Each operation update replaces the cause field. Bits 16:12 receive op_exc, where op_exc bit 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero and 4 invalid. Bit 17 receives op_unimpl.
- R5: Each operation ORs op_exc into the flag bits 6:2, in the same order. An operation never clears a flag bit.
- R6: trap_req is high in the cycle of an operation update when the updated word has op_unimpl set. It is also high when some cause bit 12+k and enable bit 7+k are both set (k = 0..4).
- R7: wb_commit is high exactly when op_valid and op_wen are high and the operation does not trap.
- R8: In the cycle after a move-to on index 31, trap_req is high when the stored word has bit 17 set, or has a cause bit 12+k together with enable bit 7+k.
- R9: The condition-code port sets or clears one code: code 0 is bit 23 and code k (1..7) is bit 24+k. cc_flags[k] shows code k.
- R10: mf_wen is low when mf_gpr is 0 and high for any other mf_gpr with mf_valid high. mf_dest echoes mf_gpr.
- R11: In a single cycle the move-to value is applied first, then the operation update, then the condition-code update. The operation's trap uses the enables from the move-to value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_valid | input | 1 | Move-to request |
| mt_idx | input | 5 | Move-to control-register index |
| mt_data | input | 32 | Move-to data |
| mf_valid | input | 1 | Move-from request |
| mf_idx | input | 5 | Move-from control-register index |
| mf_gpr | input | 5 | Destination general-purpose register |
| mf_wen | output | 1 | General-purpose register write enable |
| mf_dest | output | 5 | Destination register for the write |
| mf_data | output | 32 | Value read |
| op_valid | input | 1 | Operation update strobe |
| op_exc | input | 5 | Exception set of the operation |
| op_unimpl | input | 1 | Operation unimplemented |
| op_wen | input | 1 | Operation wants to write its result |
| wb_commit | output | 1 | Result writeback allowed |
| trap_req | output | 1 | Floating-point trap request |
| cc_wen | input | 1 | Condition-code write strobe |
| cc_sel | input | 3 | Condition code selected |
| cc_val | input | 1 | New condition-code value |
| cc_flags | output | 8 | All condition codes |
| rnd_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |

## Verification
The exception logic is driven by a table of operation updates against a fixed enable mask. The table covers no exception, unmasked-only exceptions, each enabled exception alone, a mixed set and an unimplemented operation. It therefore separates the trap decision from the cause overwrite and from the sticky flag accumulation. Each step is read back to confirm that a later clean operation clears the causes while the flags stay set. Directed patterns separate writes to index 31 from writes to other indices, and the immediate operation trap from the trap raised after a write. A final case drives all three ports in one cycle to pin their order.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int WORD_W    = 32;
  localparam int EXC_N     = 5;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + EXC_N;
  localparam int CAUSE_LSB = EN_LSB + EXC_N;
  localparam int UNIMP_BIT = CAUSE_LSB + EXC_N;
  localparam int CC_N      = 8;
  localparam int CC_SEL_W  = $clog2(CC_N);
  localparam int CC0_BIT   = 23;
  localparam int FLUSH_BIT = 24;
  localparam int CC_HI_LSB = 25;
  localparam logic [WORD_W-1:0] LIVE_MASK = 32'hFF83_FFFF;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [EXC_N-1:0]  exc_t;

  // bit position of condition code k
  function automatic int cc_bit(input int k);
    return (k == 0) ? CC0_BIT : CC_HI_LSB + k - 1;
  endfunction

  // trap test on a complete status word
  function automatic logic wants_trap(input word_t w);
    return w[UNIMP_BIT] | (|(w[CAUSE_LSB +: EXC_N] & w[EN_LSB +: EXC_N]));
  endfunction

  // merge one operation report into a word
  function automatic word_t apply_op(input word_t w, input exc_t e, input logic u);
    word_t r;
    r = w;
    r[CAUSE_LSB +: EXC_N] = e;
    r[UNIMP_BIT]          = u;
    r[FLAG_LSB +: EXC_N]  = w[FLAG_LSB +: EXC_N] | e;
    return r;
  endfunction
endpackage

// File: rtl/fcs_word_next.sv
module fcs_word_next
  import fcs_pkg::*;
(
  input  word_t                 cur,
  input  logic                  mt_fire,
  input  word_t                 mt_data,
  input  logic                  op_fire,
  input  exc_t                  op_exc,
  input  logic                  op_unimpl,
  input  logic                  cc_fire,
  input  logic [CC_SEL_W-1:0]   cc_sel,
  input  logic                  cc_val,
  output word_t                 after_op,
  output word_t                 nxt
);
  word_t after_mt;

  // stage 1: software write, stage 2: operation report, stage 3: condition code
  assign after_mt = mt_fire ? (mt_data & LIVE_MASK) : cur;
  assign after_op = op_fire ? apply_op(after_mt, op_exc, op_unimpl) : after_mt;

  always_comb begin
    nxt = after_op;
    for (int k = 0; k < CC_N; k++) begin
      if (cc_fire && cc_sel == CC_SEL_W'(k)) nxt[cc_bit(k)] = cc_val;
    end
  end
endmodule

// File: rtl/fcs_read_port.sv
module fcs_read_port
  import fcs_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int GPR_W   = 5,
  parameter int CSR_IDX = 31
) (
  input  word_t             cur,
  input  logic              mf_valid,
  input  logic [IDX_W-1:0]  mf_idx,
  input  logic [GPR_W-1:0]  mf_gpr,
  output logic              mf_wen,
  output logic [GPR_W-1:0]  mf_dest,
  output word_t             mf_data
);
  logic hit_word;

  assign hit_word = mf_valid && (mf_idx == IDX_W'(CSR_IDX));
  assign mf_data  = hit_word ? cur : '0;
  assign mf_wen   = mf_valid && (mf_gpr != '0);
  assign mf_dest  = mf_gpr;
endmodule

// File: rtl/fp_ctrl_status.sv
module fp_ctrl_status
  import fcs_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int GPR_W   = 5,
  parameter int CSR_IDX = 31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mt_valid,
  input  logic [IDX_W-1:0]       mt_idx,
  input  logic [WORD_W-1:0]      mt_data,
  input  logic                   mf_valid,
  input  logic [IDX_W-1:0]       mf_idx,
  input  logic [GPR_W-1:0]       mf_gpr,
  output logic                   mf_wen,
  output logic [GPR_W-1:0]       mf_dest,
  output logic [WORD_W-1:0]      mf_data,
  input  logic                   op_valid,
  input  logic [EXC_N-1:0]       op_exc,
  input  logic                   op_unimpl,
  input  logic                   op_wen,
  output logic                   wb_commit,
  output logic                   trap_req,
  input  logic                   cc_wen,
  input  logic [CC_SEL_W-1:0]    cc_sel,
  input  logic                   cc_val,
  output logic [CC_N-1:0]        cc_flags,
  output logic [1:0]             rnd_mode,
  output logic                   flush_zero
);
  word_t csr_q, word_nxt, word_after_op;
  logic  post_q;
  logic  mt_fire, op_trap, post_trap;

  assign mt_fire = mt_valid && (mt_idx == IDX_W'(CSR_IDX));

  fcs_word_next u_next (
    .cur      (csr_q),
    .mt_fire  (mt_fire),
    .mt_data  (mt_data),
    .op_fire  (op_valid),
    .op_exc   (op_exc),
    .op_unimpl(op_unimpl),
    .cc_fire  (cc_wen),
    .cc_sel   (cc_sel),
    .cc_val   (cc_val),
    .after_op (word_after_op),
    .nxt      (word_nxt)
  );

  fcs_read_port #(.IDX_W(IDX_W), .GPR_W(GPR_W), .CSR_IDX(CSR_IDX)) u_read (
    .cur     (csr_q),
    .mf_valid(mf_valid),
    .mf_idx  (mf_idx),
    .mf_gpr  (mf_gpr),
    .mf_wen  (mf_wen),
    .mf_dest (mf_dest),
    .mf_data (mf_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q  <= '0;
      post_q <= 1'b0;
    end else begin
      csr_q  <= word_nxt;
      post_q <= mt_fire;
    end
  end

  // named trap events
  assign op_trap   = op_valid && wants_trap(word_after_op);
  assign post_trap = post_q && wants_trap(csr_q);
  assign trap_req  = op_trap || post_trap;
  assign wb_commit = op_valid && op_wen && !op_trap;

  assign rnd_mode   = csr_q[1:0];
  assign flush_zero = csr_q[FLUSH_BIT];

  for (genvar g = 0; g < CC_N; g++) begin : g_cc
    assign cc_flags[g] = csr_q[cc_bit(g)];
  end

  // assertions
  p_rev_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_valid && mf_idx != IDX_W'(CSR_IDX)) |-> mf_data == '0);

  p_dead_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[22:18] == 5'd0);

  p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> csr_q[UNIMP_BIT:CAUSE_LSB] == $past({op_unimpl, op_exc}));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !mt_fire) |=>
      ((csr_q[FLAG_LSB +: EXC_N] & $past(csr_q[FLAG_LSB +: EXC_N])) == $past(csr_q[FLAG_LSB +: EXC_N])));

  p_wb_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_trap |-> !wb_commit);

  p_post_check_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mt_fire |=> (wants_trap(csr_q) -> trap_req));

  p_gpr0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_gpr == '0) |-> !mf_wen);
endmodule

// File: tb/tb_fp_ctrl_status.sv
module tb_fp_ctrl_status;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mt_valid, mf_valid, op_valid, op_unimpl, op_wen, cc_wen, cc_val;
  logic [4:0]  mt_idx, mf_idx, mf_gpr, op_exc;
  logic [31:0] mt_data;
  logic [2:0]  cc_sel;
  logic        mf_wen, wb_commit, trap_req, flush_zero;
  logic [4:0]  mf_dest;
  logic [31:0] mf_data;
  logic [7:0]  cc_flags;
  logic [1:0]  rnd_mode;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  fp_ctrl_status dut (
    .clk(clk), .rst_n(rst_n),
    .mt_valid(mt_valid), .mt_idx(mt_idx), .mt_data(mt_data),
    .mf_valid(mf_valid), .mf_idx(mf_idx), .mf_gpr(mf_gpr),
    .mf_wen(mf_wen), .mf_dest(mf_dest), .mf_data(mf_data),
    .op_valid(op_valid), .op_exc(op_exc), .op_unimpl(op_unimpl), .op_wen(op_wen),
    .wb_commit(wb_commit), .trap_req(trap_req),
    .cc_wen(cc_wen), .cc_sel(cc_sel), .cc_val(cc_val), .cc_flags(cc_flags),
    .rnd_mode(rnd_mode), .flush_zero(flush_zero)
  );

  // {exc[4:0], unimpl, wen, exp_trap, exp_commit}; enables: overflow and invalid
  localparam logic [8:0] OPS [8] = '{
    {5'b00000, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'b00001, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'b00100, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'b00010, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'b10000, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'b01000, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'b00000, 1'b1, 1'b1, 1'b1, 1'b0},
    {5'b01011, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic mt_write(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    mt_valid = 1'b1; mt_idx = idx; mt_data = d;
    @(posedge clk); #1;
    mt_valid = 1'b0;
  endtask

  task automatic read_word(input logic [4:0] idx, output logic [31:0] v);
    @(negedge clk);
    mf_valid = 1'b1; mf_idx = idx; mf_gpr = 5'd7;
    #2 v = mf_data;
    @(posedge clk); #1;
    mf_valid = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] e, input logic u, input logic w,
                       output logic t, output logic c);
    @(negedge clk);
    op_valid = 1'b1; op_exc = e; op_unimpl = u; op_wen = w;
    #2 t = trap_req; c = wb_commit;
    @(posedge clk); #1;
    op_valid = 1'b0;
  endtask

  task automatic set_cc(input logic [2:0] k, input logic v);
    @(negedge clk);
    cc_wen = 1'b1; cc_sel = k; cc_val = v;
    @(posedge clk); #1;
    cc_wen = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, model;
    logic t, c;
    rst_n = 1'b0;
    mt_valid = 0; mf_valid = 0; op_valid = 0; op_unimpl = 0; op_wen = 0;
    cc_wen = 0; cc_val = 0; mt_idx = 0; mf_idx = 0; mf_gpr = 0; op_exc = 0;
    mt_data = 0; cc_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 rnd_mode", 32'(rnd_mode), 0);
    check("R1 flush", 32'(flush_zero), 0);
    check("R1 cc_flags", 32'(cc_flags), 0);
    check("R1 trap", 32'(trap_req), 0);
    read_word(5'd31, v); check("R1 word", v, 0);

    // R2 other indices
    mt_write(5'd5, 32'hFFFF_FFFF);
    check("R2 no post trap", 32'(trap_req), 0);
    read_word(5'd31, v); check("R2 word untouched", v, 0);
    read_word(5'd0, v);  check("R2 revision reads zero", v, 0);

    // R3 write all ones; R8 unimplemented cause traps after write; R9 codes
    mt_write(5'd31, 32'hFFFF_FFFF);
    check("R8 post-write trap unimpl", 32'(trap_req), 1);
    check("R3 rnd_mode", 32'(rnd_mode), 3);
    check("R3 flush", 32'(flush_zero), 1);
    check("R9 cc all", 32'(cc_flags), 32'hFF);
    read_word(5'd31, v); check("R3 masked word", v, 32'hFF83_FFFF);
    read_word(5'd5, v);  check("R2 other index reads zero", v, 0);

    for (int m = 0; m < 4; m++) begin
      mt_write(5'd31, 32'(m) | ((m % 2 == 1) ? 32'h0100_0000 : 32'h0));
      check("R3 mode", 32'(rnd_mode), 32'(m));
      check("R3 flush bit", 32'(flush_zero), (m % 2 == 1) ? 1 : 0);
      check("R8 no trap", 32'(trap_req), 0);
    end

    // R8 enabled underflow cause written by software
    mt_write(5'd31, 32'h0000_2100);
    check("R8 enabled cause trap", 32'(trap_req), 1);
    @(posedge clk); #1;
    check("R8 trap is one cycle", 32'(trap_req), 0);

    // R4 R5 R6 R7 table
    mt_write(5'd31, 32'h0000_0A00);
    model = 32'h0000_0A00;
    for (int i = 0; i < 8; i++) begin
      do_op(OPS[i][8:4], OPS[i][3], OPS[i][2], t, c);
      check("R6 trap", 32'(t), 32'(OPS[i][1]));
      check("R7 commit", 32'(c), 32'(OPS[i][0]));
      model[17:12] = {OPS[i][3], OPS[i][8:4]};
      model[6:2]   = model[6:2] | OPS[i][8:4];
      read_word(5'd31, v);
      check("R4 R5 word after op", v, model);
    end

    // R9 condition codes
    mt_write(5'd31, 32'h0);
    set_cc(3'd0, 1'b1);
    set_cc(3'd5, 1'b1);
    read_word(5'd31, v); check("R9 code bits", v, 32'h2080_0000);
    check("R9 cc_flags", 32'(cc_flags), 32'h21);
    set_cc(3'd0, 1'b0);
    read_word(5'd31, v); check("R9 clear code 0", v, 32'h2000_0000);

    // R10 register zero
    @(negedge clk);
    mf_valid = 1'b1; mf_idx = 5'd31; mf_gpr = 5'd0;
    #2 check("R10 gpr0 no write", 32'(mf_wen), 0);
    mf_gpr = 5'd9;
    #1 check("R10 write enable", 32'(mf_wen), 1);
    check("R10 dest", 32'(mf_dest), 9);
    @(posedge clk); #1 mf_valid = 1'b0;

    // R11 all ports in one cycle
    @(negedge clk);
    mt_valid = 1'b1; mt_idx = 5'd31; mt_data = 32'h0000_0100;
    op_valid = 1'b1; op_exc = 5'b00010; op_unimpl = 1'b0; op_wen = 1'b1;
    cc_wen = 1'b1; cc_sel = 3'd0; cc_val = 1'b1;
    #2 check("R11 op trap uses new enables", 32'(trap_req), 1);
    check("R11 writeback blocked", 32'(wb_commit), 0);
    @(posedge clk); #1;
    mt_valid = 0; op_valid = 0; cc_wen = 0;
    check("R11 post-write trap", 32'(trap_req), 1);
    read_word(5'd31, v); check("R11 merged word", v, 32'h0080_2108);

    summary();
    $finish;
  end
endmodule